// File: doc/BRIEF.md
# Asynchronous DRAM Device Cycle Decoder

This block is a synthesizable stand-in for the control logic inside an asynchronous page-mode DRAM. It is used as the memory side of a bench when a DRAM controller is verified. It watches the active-low row strobe, column strobe, write enable and output enable, together with the multiplexed address and the data input. From the order in which the strobe edges arrive it works out what kind of cycle the controller is running. It latches the row and column halves of the address and reads or writes a small internal cell array. It also keeps a refresh row counter, times the entry into self refresh, and drives the data output with an enable in extended-data-out fashion.

The strobes, address and data pass together through a synchronizer of `SYNC_STAGES` flops. Edges are then found on the system clock, so the model is exact only to clock resolution. Every completed cycle is reported with a one-clock `cyc_valid` pulse, a 3-bit kind code and a page flag. The kind codes are: 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 self refresh.

A single state machine drives the decoding. Its states are:
- IDLE: both strobes high.
- ROW: row open, column strobe high.
- RD: column access in read.
- WR: column access whose write is done.
- CASPRE: column strobe low while the row strobe is high.
- CBR: column-before-row refresh.
- SELF: self refresh.

Its transitions are:
- row-open: IDLE/CASPRE to ROW.
- refresh-start: IDLE/CASPRE to CBR.
- column-read: ROW to RD.
- early-write: ROW to WR.
- late-write: RD to WR.
- access-end: RD/WR to ROW, IDLE or CASPRE.
- column-first: IDLE to CASPRE.
- column-release: CASPRE to IDLE.
- sleep: CBR to SELF.
- row-close: any row-low state to IDLE or CASPRE.

Top module: `dram_cycle_decoder`

## Requirements
- R1: A row-strobe fall with the column strobe high latches `addr` as the row. Each column-strobe fall while the row strobe is low latches `addr` as the column, and the cell index is {row, column}. The first access in a row-low period reports `cyc_page`=0, and every later access in that period reports `cyc_page`=1.
- R2: A column-strobe fall with write enable high reads the cell onto `dout`. `dout_en` is 1 while output enable is low and write enable is high. When the access ends, kind 1 is reported.
- R3: After the column strobe rises, read data stays on `dout` with `dout_en`=1 while the row strobe and output enable are low and write enable is high.
- R4: `dout_en` goes to 0 when both strobes are high or output enable is high. It also goes to 0 when write enable falls, and it stays 0 after write enable rises again until the next read.
- R5: Write enable low at the column-strobe fall stores `din` into the cell. `dout_en` stays 0 through the access, even with output enable low, and kind 2 is reported.
- R6: If write enable falls during a read access and the output was never enabled in that access, the `din` present at the write-enable fall is stored and kind 3 is reported.
- R7: If the output was enabled during a read access and write enable then falls, the old cell value is driven first and the `din` present at the fall is stored afterwards. Kind 4 is reported.
- R8: A row-low period with no column access reports kind 5 at the row-strobe rise and leaves the array unchanged.
- R9: A row-strobe fall with the column strobe already low increments `refresh_count` by one, wrapping at 2^ROW_W. It ignores `addr`, leaves the array unchanged and reports kind 6 at the row-strobe rise.
- R10: If the column strobe stays low from a read through a row-strobe rise and a new row-strobe fall, a refresh is performed and the read data stays on `dout`.
- R11: When both strobes stay low for `SREF_CYCLES` clocks after a column-before-row start, `sref_active` goes to 1. The column strobe has no effect on it from then on. A row-strobe rise clears it and reports kind 7.
- R12: After reset `dout_en`, `cyc_valid`, `sref_active` and `refresh_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Read data is driven (0 means high impedance) |
| cyc_valid | output | 1 | One-clock pulse when a cycle is classified |
| cyc_type | output | 3 | Kind code of the classified cycle |
| cyc_page | output | 1 | Access was not the first in its row-low period |
| refresh_count | output | ROW_W | Internal refresh row counter |
| sref_active | output | 1 | Self refresh in progress |

## Verification
A refresh and a data read can be live at the same time. In a hidden refresh the column strobe is held low after a read while the row strobe rises and falls again, so the refresh counter steps in the same stretch that the read data must stay driven. The bench provokes this directly. It checks that `refresh_count` advanced and that `dout` and `dout_en` kept the earlier value. The scoreboard must also see the read report and then the refresh report, in that order.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

    typedef enum logic [2:0] {
        CT_NONE     = 3'd0,
        CT_READ     = 3'd1,
        CT_EWRITE   = 3'd2,
        CT_LWRITE   = 3'd3,
        CT_RMW      = 3'd4,
        CT_RAS_ONLY = 3'd5,
        CT_CBR      = 3'd6,
        CT_SELF     = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RD,
        ST_WR,
        ST_CASPRE,
        ST_CBR,
        ST_SELF
    } dec_state_e;

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= RST_VAL;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dram_sref_timer.sv
module dram_sref_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = en && (cnt == LAST);

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dram_dec_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int COL_W       = 4,
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SREF_CYCLES = 20000,
    localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              cyc_valid,
    output logic [2:0]        cyc_type,
    output logic              cyc_page,
    output logic [ROW_W-1:0]  refresh_count,
    output logic              sref_active
);

    localparam int SYNC_W = 4 + ADDR_W + DATA_W;
    localparam int CELL_W = ROW_W + COL_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

    // synchronized inputs
    logic [SYNC_W-1:0] sync_q;
    logic              ras_q, cas_q, we_q, oe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;

    dram_strobe_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ras_n, cas_n, we_n, oe_n, addr, din}),
        .q     (sync_q)
    );

    assign {ras_q, cas_q, we_q, oe_q, addr_q, din_q} = sync_q;

    // edge detection
    logic ras_p, cas_p, we_p;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_p <= 1'b1;
            cas_p <= 1'b1;
            we_p  <= 1'b1;
        end else begin
            ras_p <= ras_q;
            cas_p <= cas_q;
            we_p  <= we_q;
        end
    end

    assign ras_fall = ras_p & ~ras_q;
    assign ras_rise = ~ras_p & ras_q;
    assign cas_fall = cas_p & ~cas_q;
    assign cas_rise = ~cas_p & cas_q;
    assign we_fall  = we_p & ~we_q;

    // state machine
    dec_state_e state, state_n;
    logic       sref_expired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) begin
                    state_n = cas_q ? ST_ROW : ST_CBR;
                end else if (cas_fall) begin
                    state_n = ST_CASPRE;
                end
            end
            ST_ROW: begin
                if (ras_rise) begin
                    state_n = cas_q ? ST_IDLE : ST_CASPRE;
                end else if (cas_fall) begin
                    state_n = we_q ? ST_RD : ST_WR;
                end
            end
            ST_RD: begin
                if (ras_rise) begin
                    state_n = cas_q ? ST_IDLE : ST_CASPRE;
                end else if (cas_rise) begin
                    state_n = ST_ROW;
                end else if (we_fall) begin
                    state_n = ST_WR;
                end
            end
            ST_WR: begin
                if (ras_rise) begin
                    state_n = cas_q ? ST_IDLE : ST_CASPRE;
                end else if (cas_rise) begin
                    state_n = ST_ROW;
                end
            end
            ST_CASPRE: begin
                if (ras_fall) begin
                    state_n = cas_q ? ST_ROW : ST_CBR;
                end else if (cas_rise) begin
                    state_n = ST_IDLE;
                end
            end
            ST_CBR: begin
                if (ras_rise) begin
                    state_n = cas_q ? ST_IDLE : ST_CASPRE;
                end else if (sref_expired) begin
                    state_n = ST_SELF;
                end
            end
            ST_SELF: begin
                if (ras_rise) begin
                    state_n = cas_q ? ST_IDLE : ST_CASPRE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // transition events
    logic row_open, col_rd, col_wr, late_wr, acc_end;
    logic ras_only, cbr_start, cbr_end, self_end;
    logic first_done;

    assign row_open  = (state == ST_IDLE || state == ST_CASPRE) && (state_n == ST_ROW);
    assign cbr_start = (state != ST_CBR) && (state_n == ST_CBR);
    assign col_rd    = (state == ST_ROW) && (state_n == ST_RD);
    assign col_wr    = (state == ST_ROW) && (state_n == ST_WR);
    assign late_wr   = (state == ST_RD) && (state_n == ST_WR);
    assign acc_end   = (state == ST_RD || state == ST_WR) &&
                       (state_n == ST_ROW || state_n == ST_IDLE || state_n == ST_CASPRE);
    assign ras_only  = (state == ST_ROW) && ras_rise && !first_done;
    assign cbr_end   = (state == ST_CBR) && ras_rise;
    assign self_end  = (state == ST_SELF) && ras_rise;

    // refresh counter and self-refresh timer
    dram_refresh_ctr #(
        .W (ROW_W)
    ) u_rctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cbr_start),
        .count (refresh_count)
    );

    dram_sref_timer #(
        .LIMIT (SREF_CYCLES)
    ) u_stmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      ((state == ST_CBR) && !ras_q && !cas_q),
        .expired (sref_expired)
    );

    // cell array
    logic [ROW_W-1:0]  row_reg;
    logic [COL_W-1:0]  col_reg;
    logic              arr_we;
    logic [CELL_W-1:0] arr_waddr, arr_raddr;
    logic [DATA_W-1:0] arr_rdata;

    assign arr_we    = col_wr || late_wr;
    assign arr_waddr = col_wr ? {row_reg, addr_q[COL_W-1:0]} : {row_reg, col_reg};
    assign arr_raddr = {row_reg, addr_q[COL_W-1:0]};

    dram_cell_array #(
        .AW (CELL_W),
        .DW (DATA_W)
    ) u_cells (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (din_q),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    // outputs and datapath
    logic [DATA_W-1:0] dout_reg;
    logic              data_valid;
    logic              rmw_seen;
    logic              acc_page;
    cyc_kind_e         acc_kind;

    assign dout        = dout_reg;
    assign dout_en     = data_valid && !oe_q && we_q;
    assign sref_active = (state == ST_SELF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_reg    <= '0;
            col_reg    <= '0;
            dout_reg   <= '0;
            data_valid <= 1'b0;
            first_done <= 1'b0;
            rmw_seen   <= 1'b0;
            acc_page   <= 1'b0;
            acc_kind   <= CT_NONE;
            cyc_valid  <= 1'b0;
            cyc_type   <= CT_NONE;
            cyc_page   <= 1'b0;
        end else begin
            cyc_valid <= 1'b0;
            if (row_open) begin
                row_reg    <= addr_q[ROW_W-1:0];
                first_done <= 1'b0;
            end
            if (col_rd || col_wr) begin
                col_reg    <= addr_q[COL_W-1:0];
                acc_page   <= first_done;
                first_done <= 1'b1;
            end
            if (col_rd) begin
                dout_reg   <= arr_rdata;
                data_valid <= 1'b1;
                acc_kind   <= CT_READ;
                rmw_seen   <= 1'b0;
            end
            if (col_wr) begin
                data_valid <= 1'b0;
                acc_kind   <= CT_EWRITE;
            end
            if ((state == ST_RD) && dout_en) begin
                rmw_seen <= 1'b1;
            end
            if (late_wr) begin
                acc_kind   <= rmw_seen ? CT_RMW : CT_LWRITE;
                data_valid <= 1'b0;
            end
            if (acc_end) begin
                cyc_valid <= 1'b1;
                cyc_type  <= acc_kind;
                cyc_page  <= acc_page;
            end
            if (ras_only) begin
                cyc_valid <= 1'b1;
                cyc_type  <= CT_RAS_ONLY;
                cyc_page  <= 1'b0;
            end
            if (cbr_end) begin
                cyc_valid <= 1'b1;
                cyc_type  <= CT_CBR;
                cyc_page  <= 1'b0;
            end
            if (self_end) begin
                cyc_valid <= 1'b1;
                cyc_type  <= CT_SELF;
                cyc_page  <= 1'b0;
            end
            if (we_fall) begin
                data_valid <= 1'b0;
            end
            if (ras_q && cas_q) begin
                data_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk
    import dram_dec_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input dec_state_e       state,
    input dec_state_e       state_n,
    input logic             ras_q,
    input logic             cas_q,
    input logic             ras_rise,
    input logic             dout_en,
    input logic             cyc_valid,
    input logic [2:0]       cyc_type,
    input logic [ROW_W-1:0] refresh_count,
    input logic             arr_we
);

    // R4
    both_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_q && cas_q) |=> !dout_en);

    // R5
    wr_state_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR) |-> !dout_en);

    // R9
    cbr_increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CBR && state_n == ST_CBR) |=>
        (refresh_count == ROW_W'($past(refresh_count) + 1'b1)));

    // R11
    self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SELF && state_n == ST_SELF) |-> (state == ST_CBR));

    // R11
    self_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELF && ras_rise) |=> (state != ST_SELF));

    // R1
    report_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_type != 3'd0));

    // R6
    array_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (state == ST_ROW || state == ST_RD));

endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ROW_W(ROW_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .state_n       (state_n),
    .ras_q         (ras_q),
    .cas_q         (cas_q),
    .ras_rise      (ras_rise),
    .dout_en       (dout_en),
    .cyc_valid     (cyc_valid),
    .cyc_type      (cyc_type),
    .refresh_count (refresh_count),
    .arr_we        (arr_we)
);

// File: tb/dram_cycle_decoder_test.sv
`timescale 1ns/1ps
module dram_cycle_decoder_test;

    localparam int S = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_en, cyc_valid, cyc_page, sref_active;
    logic [2:0] cyc_type;
    logic [3:0] refresh_count;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] expq [$];

    always #2.5 clk = ~clk;

    dram_cycle_decoder #(.SREF_CYCLES(100)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_page(cyc_page),
        .refresh_count(refresh_count), .sref_active(sref_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int t, input bit pg);
        expq.push_back({t[2:0], pg});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected report: actual %0h expected none", {cyc_type, cyc_page});
            end else begin
                logic [3:0] e;
                e = expq.pop_front();
                if ({cyc_type, cyc_page} !== e) begin
                    n_fail++;
                    $display("FAIL R1 cycle report {kind,page}: actual %0h expected %0h",
                             {cyc_type, cyc_page}, e);
                end
            end
        end
    end

    task automatic open_row(input int r);
        addr = r[3:0];
        step(1);
        ras_n = 1'b0;
        step(S);
    endtask

    task automatic close_row();
        ras_n = 1'b1;
        step(S);
    endtask

    task automatic ewr(input int c, input int d, input bit pg);
        push(2, pg);
        addr = c[3:0];
        din = d[3:0];
        we_n = 1'b0;
        step(1);
        cas_n = 1'b0;
        step(S);
        chk("R5 early write output off", dout_en, 0);
        cas_n = 1'b1;
        step(S);
        we_n = 1'b1;
        step(S);
    endtask

    task automatic rd(input int c, input int exp, input bit pg);
        push(1, pg);
        addr = c[3:0];
        we_n = 1'b1;
        step(1);
        cas_n = 1'b0;
        step(S);
        chk("R2 read enable", dout_en, 1);
        chk("R2 read data", dout, exp);
        cas_n = 1'b1;
        step(S);
        chk("R3 EDO hold enable", dout_en, 1);
        chk("R3 EDO hold data", dout, exp);
    endtask

    task automatic cbr();
        push(6, 0);
        cas_n = 1'b0;
        step(S);
        addr = 4'h5;
        ras_n = 1'b0;
        step(S);
        ras_n = 1'b1;
        step(S);
        cas_n = 1'b1;
        step(S);
    endtask

    initial begin
        step(5);
        chk("R12 reset dout_en", dout_en, 0);
        chk("R12 reset cyc_valid", cyc_valid, 0);
        chk("R12 reset refresh_count", refresh_count, 0);
        chk("R12 reset sref_active", sref_active, 0);
        rst_n = 1'b1;
        step(3);
        oe_n = 1'b0;

        // R5 early writes, R1 page flag
        open_row(3);
        ewr(5, 'hA, 0);
        ewr(6, 'h5, 1);
        close_row();

        // R2/R3 reads, R1 page
        open_row(3);
        rd(5, 'hA, 0);
        rd(6, 'h5, 1);
        oe_n = 1'b1;
        step(S);
        chk("R4 OE high off", dout_en, 0);
        oe_n = 1'b0;
        step(S);
        chk("R3 data back with OE low", dout_en, 1);
        close_row();
        chk("R4 both strobes high off", dout_en, 0);

        // R4 write enable fall during hold
        open_row(3);
        rd(5, 'hA, 0);
        we_n = 1'b0;
        step(S);
        chk("R4 WE low off", dout_en, 0);
        we_n = 1'b1;
        step(S);
        chk("R4 stays off after WE rise", dout_en, 0);
        close_row();

        // R1 row separation
        open_row(9);
        ewr(5, 'h3, 0);
        close_row();
        open_row(3);
        rd(5, 'hA, 0);
        close_row();
        open_row(9);
        rd(5, 'h3, 0);
        close_row();

        // R6 late write
        oe_n = 1'b1;
        open_row(3);
        push(3, 0);
        addr = 4'h7;
        we_n = 1'b1;
        step(1);
        cas_n = 1'b0;
        step(S);
        din = 4'hC;
        we_n = 1'b0;
        step(S);
        chk("R6 late write output off", dout_en, 0);
        cas_n = 1'b1;
        step(S);
        we_n = 1'b1;
        oe_n = 1'b0;
        step(S);
        close_row();
        open_row(3);
        rd(7, 'hC, 0);
        close_row();

        // R7 read-modify-write
        open_row(3);
        push(4, 0);
        addr = 4'h5;
        we_n = 1'b1;
        step(1);
        cas_n = 1'b0;
        step(S);
        chk("R7 old value driven", dout_en, 1);
        chk("R7 old value", dout, 'hA);
        din = 4'h9;
        we_n = 1'b0;
        step(S);
        chk("R7 output off after WE fall", dout_en, 0);
        cas_n = 1'b1;
        step(S);
        we_n = 1'b1;
        step(S);
        close_row();
        open_row(3);
        rd(5, 'h9, 0);
        close_row();

        // R8 row-only refresh
        push(5, 0);
        open_row(3);
        close_row();
        open_row(3);
        rd(5, 'h9, 0);
        close_row();

        // R9 refresh before row
        cbr();
        chk("R9 refresh count step", refresh_count, 1);
        open_row(3);
        rd(5, 'h9, 0);
        close_row();

        // R10 hidden refresh
        open_row(3);
        push(1, 0);
        addr = 4'h6;
        step(1);
        cas_n = 1'b0;
        step(S);
        chk("R10 read before hidden refresh", dout, 'h5);
        ras_n = 1'b1;
        step(S);
        chk("R10 held across row rise", dout_en, 1);
        push(6, 0);
        ras_n = 1'b0;
        step(S);
        chk("R10 hidden refresh count", refresh_count, 2);
        chk("R10 data held enable", dout_en, 1);
        chk("R10 data held value", dout, 'h5);
        ras_n = 1'b1;
        step(S);
        cas_n = 1'b1;
        step(S);
        chk("R10 off after release", dout_en, 0);

        // R9 wrap
        for (int i = 0; i < 14; i++) begin
            cbr();
        end
        chk("R9 refresh count wrap", refresh_count, 0);

        // R11 self refresh
        push(7, 0);
        cas_n = 1'b0;
        step(S);
        ras_n = 1'b0;
        step(50);
        chk("R11 not yet in self refresh", sref_active, 0);
        step(80);
        chk("R11 self refresh entered", sref_active, 1);
        chk("R11 entry counted as refresh", refresh_count, 1);
        cas_n = 1'b1;
        step(S);
        chk("R11 column strobe ignored", sref_active, 1);
        ras_n = 1'b1;
        step(S);
        chk("R11 self refresh left", sref_active, 0);

        step(10);
        chk("R1 scoreboard drained", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule